// File: doc/BRIEF.md
# Scalar Single-Precision Reciprocal Square Root Unit

This unit takes one IEEE-754 binary32 operand from the low lane of a 128-bit source vector and returns an approximation of one over its square root. The result goes into the low lane of a 128-bit result vector. Bits 127:32 of the result are copied from a second 128-bit vector. Each operation arrives with a write-mask bit. When masking is active and that bit is clear, the computed value is dropped. The low lane is then either filled with zero or keeps its prior content, which the caller supplies with the operation.

Finite positive operands go through a small seed table indexed by exponent parity and the leading fraction bits. Fixed-point Newton-Raphson steps then refine the seed to well under 2^-28 relative error. A round-to-nearest-even packer builds the binary32 word. Non-finite, zero, denormal and negative operands take a fixed special-case path. That path also produces the invalid and divide-by-zero indications. These indications are per-operation pulses that travel with the result; they are not accumulated. Operations enter and leave through valid/ready handshakes, and each result is produced one cycle after acceptance.

Top module: `rsqrt_unit`

## Requirements
- R1: For a positive normal operand x, the low lane of the result is a binary32 value r with |r − 1/√x| / (1/√x) < 2^-23, and neither flag is set.
- R2: For an operand exactly equal to 2^(−2n), with the fraction field zero and the exponent field odd, the low lane is exactly 2^n.
- R3: A NaN operand (exponent field 0xFF, fraction non-zero) returns the same word with fraction bit 22 forced to 1. The invalid flag is set only if fraction bit 22 of the operand was 0 (signalling NaN).
- R4: Negative infinity and every negative normal operand return 0xFFC00000 and set the invalid flag.
- R5: An exponent field of zero (zero or denormal) is treated as a zero of the same sign. It returns 0x7F800000 for sign 0 and 0xFF800000 for sign 1, and sets the divide-by-zero flag. The invalid and divide-by-zero flags are never both set.
- R6: Positive infinity returns 0x00000000 with neither flag set.
- R7: If mask enable is 0 or the mask bit is 1, the low lane takes the computed value. Otherwise, with zeroing mode 1 the low lane is 0, and with zeroing mode 0 it equals the supplied prior low lane. Neither flag is set for a masked-off lane.
- R8: Result bits 127:32 always equal bits 127:32 of the pass-through source, whatever the mask.
- R9: Each accepted operation yields exactly one result, in acceptance order, with out_valid high in the cycle after acceptance. While out_valid is high and out_ready low, the result and flags hold steady.
- R10: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| in_src1 | input | 128 | Pass-through source for result bits 127:32 |
| in_src2 | input | 128 | Operand source; bits 31:0 hold the binary32 operand |
| in_dst_lo | input | 32 | Prior low lane, kept when merging a masked-off lane |
| in_mask_en | input | 1 | 1 applies the mask bit, 0 always writes the lane |
| in_mask_bit | input | 1 | Write-mask bit for the low lane |
| in_zeroing | input | 1 | 1 zeroes a masked-off lane, 0 merges it |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 128 | Result vector |
| out_invalid | output | 1 | Invalid-operation indication for this result |
| out_divzero | output | 1 | Divide-by-zero indication for this result |

## Verification
The embedded properties assume that the consumer obeys the output handshake. They also assume that inputs are stable around the rising edge, and that the refinement checks see only operands the classifier marks as positive normals. The stimulus changes inputs on the falling edge. It holds each offered operation until it sees in_ready high before a rising edge, and it drives out_ready from an independent stall pattern. Operands are chosen class by class: NaNs of both kinds, signed zeros and denormals, infinities, negative normals, exact even powers of two, and random positive normals across the full exponent range. Each class is combined with every masking mode, and a random pass-through vector goes with every operation.

// File: rtl/rsqrt_pkg.sv
`timescale 1ns/1ps
package rsqrt_pkg;

   typedef enum logic [2:0] {
      CL_NORMAL,
      CL_NAN,
      CL_ZERO,
      CL_PINF,
      CL_NEG
   } op_class_e;

   localparam logic [31:0] QNAN_INDEF = 32'hFFC0_0000;
   localparam logic [31:0] POS_INF    = 32'h7F80_0000;
   localparam logic [31:0] NEG_INF    = 32'hFF80_0000;

   // Largest Y with Y*Y*a_mid <= 2^(2*sf), a_mid taken at the centre of the
   // table interval; odd parity doubles the mantissa range to [2,4).
   function automatic longint seed_value(int idx, int sb, int sf);
      longint frac_idx;
      longint a_num;
      longint limit;
      longint lo;
      longint hi;
      longint mid;
      frac_idx = longint'(idx) & ((longint'(1) << sb) - 1);
      a_num    = (((longint'(1) << sb) + frac_idx) << 1) + 1;
      if (((idx >> sb) & 1) == 1) a_num = a_num << 1;
      limit = longint'(1) << (2 * sf + sb + 1);
      lo = 0;
      hi = longint'(1) << sf;
      while (hi - lo > 1) begin
         mid = (lo + hi) >> 1;
         if (mid * mid * a_num <= limit) lo = mid;
         else hi = mid;
      end
      return lo;
   endfunction

endpackage

// File: rtl/rsqrt_classify.sv
`timescale 1ns/1ps
module rsqrt_classify
   import rsqrt_pkg::*;
(
   input  logic [31:0] op,
   output op_class_e   cls,
   output logic [31:0] spec_res,
   output logic        spec_inv,
   output logic        spec_dz
);

   logic       sgn;
   logic [7:0] ex;
   logic [22:0] fr;

   assign sgn = op[31];
   assign ex  = op[30:23];
   assign fr  = op[22:0];

   always_comb begin
      cls      = CL_NORMAL;
      spec_res = 32'h0;
      spec_inv = 1'b0;
      spec_dz  = 1'b0;
      if (ex == 8'hFF && fr != 23'd0) begin
         cls      = CL_NAN;
         spec_res = op | 32'h0040_0000;
         spec_inv = ~fr[22];
      end else if (ex == 8'h00) begin
         cls      = CL_ZERO;
         spec_res = sgn ? NEG_INF : POS_INF;
         spec_dz  = 1'b1;
      end else if (ex == 8'hFF && !sgn) begin
         cls      = CL_PINF;
         spec_res = 32'h0;
      end else if (sgn) begin
         cls      = CL_NEG;
         spec_res = QNAN_INDEF;
         spec_inv = 1'b1;
      end
   end

endmodule

// File: rtl/rsqrt_seed_rom.sv
`timescale 1ns/1ps
module rsqrt_seed_rom
   import rsqrt_pkg::*;
#(
   parameter int SEED_IDX  = 6,
   parameter int SEED_FRAC = 12
)(
   input  logic [SEED_IDX:0]  idx,
   output logic [SEED_FRAC:0] seed
);

   localparam int ENTRIES = 2 ** (SEED_IDX + 1);

   if (SEED_IDX < 4 || SEED_IDX > 8) begin : g_bad_idx
      $error("rsqrt_seed_rom: SEED_IDX must lie in 4..8");
   end
   if (SEED_FRAC < SEED_IDX + 2 || SEED_FRAC > 20) begin : g_bad_frac
      $error("rsqrt_seed_rom: SEED_FRAC must lie in SEED_IDX+2..20");
   end

   logic [SEED_FRAC:0] table_q [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      localparam longint VAL = seed_value(i, SEED_IDX, SEED_FRAC);
      assign table_q[i] = VAL[SEED_FRAC:0];
   end

   assign seed = table_q[idx];

endmodule

// File: rtl/rsqrt_newton.sv
`timescale 1ns/1ps
module rsqrt_newton #(
   parameter int FRAC_BITS = 32,
   parameter int STEPS     = 2
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 chk_en,
   input  logic [24:0]          a_q,
   input  logic [FRAC_BITS+1:0] y_seed,
   output logic [FRAC_BITS+1:0] y_out
);

   localparam int W  = FRAC_BITS + 2;
   localparam int AW = 25;
   localparam logic [W-1:0] THREE = W'(3) << FRAC_BITS;
   localparam logic [W-1:0] HALF  = W'(1) << (FRAC_BITS - 1);
   localparam logic [W-1:0] ONE   = W'(1) << FRAC_BITS;

   if (STEPS < 1 || STEPS > 3) begin : g_bad_steps
      $error("rsqrt_newton: STEPS must lie in 1..3");
   end
   if (FRAC_BITS < 32 || FRAC_BITS > 48) begin : g_bad_fb
      $error("rsqrt_newton: FRAC_BITS must lie in 32..48");
   end

   logic [W-1:0] y_chain [STEPS+1];
   assign y_chain[0] = y_seed;

   for (genvar s = 0; s < STEPS; s++) begin : g_step
      logic [2*W-1:0]  sq;
      logic [W-1:0]    y_sq;
      logic [W+AW-1:0] ay;
      logic [W-1:0]    ay_sq;
      logic [W-1:0]    corr;
      logic [2*W-1:0]  upd;

      assign sq    = {{W{1'b0}}, y_chain[s]} * {{W{1'b0}}, y_chain[s]};
      assign y_sq  = sq[FRAC_BITS +: W];
      assign ay    = {{W{1'b0}}, a_q} * {{AW{1'b0}}, y_sq};
      assign ay_sq = ay[23 +: W];
      assign corr  = THREE - ay_sq;
      assign upd   = {{W{1'b0}}, y_chain[s]} * {{W{1'b0}}, corr};
      assign y_chain[s+1] = upd[FRAC_BITS+1 +: W];
   end

   assign y_out = y_chain[STEPS];

   // R1
   refine_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en |-> (y_out >= HALF && y_out <= ONE))
      else $error("refined estimate outside (0.5,1]");

endmodule

// File: rtl/rsqrt_round_pack.sv
`timescale 1ns/1ps
module rsqrt_round_pack #(
   parameter int FRAC_BITS = 32
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 chk_en,
   input  logic [FRAC_BITS+1:0] y,
   input  logic [7:0]           op_exp,
   output logic [31:0]          res
);

   localparam int W = FRAC_BITS + 2;

   logic              hi;
   logic [W-1:0]      norm;
   logic [23:0]       mant;
   logic              rbit;
   logic              sticky;
   logic [24:0]       rnd;
   logic              carry;
   logic signed [9:0] e_unb;
   logic signed [9:0] half_e;
   logic signed [9:0] bexp;

   assign hi     = y[FRAC_BITS];
   assign norm   = hi ? y : (y << 1);
   assign mant   = norm[FRAC_BITS -: 24];
   assign rbit   = norm[FRAC_BITS-24];
   assign sticky = |norm[FRAC_BITS-25:0];
   assign rnd    = {1'b0, mant} + {24'd0, rbit & (sticky | mant[0])};
   assign carry  = rnd[24];

   assign e_unb  = $signed({2'b00, op_exp}) - 10'sd127;
   assign half_e = e_unb >>> 1;
   assign bexp   = 10'sd127 - half_e - (hi ? 10'sd0 : 10'sd1) + (carry ? 10'sd1 : 10'sd0);

   assign res = {1'b0, bexp[7:0], carry ? 23'd0 : rnd[22:0]};

   // R2
   pack_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en |-> (res[30:23] != 8'h00 && res[30:23] != 8'hFF))
      else $error("packed exponent left the normal range");

endmodule

// File: rtl/rsqrt_unit.sv
`timescale 1ns/1ps
module rsqrt_unit
   import rsqrt_pkg::*;
#(
   parameter int VEC_W     = 128,
   parameter int SEED_IDX  = 6,
   parameter int SEED_FRAC = 12,
   parameter int FRAC_BITS = 32,
   parameter int NR_STEPS  = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [VEC_W-1:0] in_src1,
   input  logic [VEC_W-1:0] in_src2,
   input  logic [31:0]      in_dst_lo,
   input  logic             in_mask_en,
   input  logic             in_mask_bit,
   input  logic             in_zeroing,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [VEC_W-1:0] out_data,
   output logic             out_invalid,
   output logic             out_divzero
);

   localparam int LANE = 32;
   localparam int W    = FRAC_BITS + 2;

   if (VEC_W < 2 * LANE || (VEC_W % LANE) != 0) begin : g_bad_vec
      $error("rsqrt_unit: VEC_W must be a multiple of 32 and at least 64");
   end

   logic [LANE-1:0] op;
   logic            fire;
   op_class_e       cls;
   logic [31:0]     spec_res;
   logic            spec_inv;
   logic            spec_dz;
   logic [SEED_FRAC:0] seed;
   logic [24:0]     a_q;
   logic [W-1:0]    y_seed;
   logic [W-1:0]    y_fin;
   logic [31:0]     norm_res;
   logic            calc_en;
   logic            lane_on;
   logic [31:0]     lane_val;
   logic            unused_bits;

   assign op          = in_src2[LANE-1:0];
   assign unused_bits = ^{in_src2[VEC_W-1:LANE], in_src1[LANE-1:0]};
   assign in_ready    = !out_valid || out_ready;
   assign fire        = in_valid && in_ready;

   rsqrt_classify u_cls (
      .op       (op),
      .cls      (cls),
      .spec_res (spec_res),
      .spec_inv (spec_inv),
      .spec_dz  (spec_dz)
   );

   // op[23] is the exponent LSB: 0 means the unbiased exponent is odd
   rsqrt_seed_rom #(.SEED_IDX(SEED_IDX), .SEED_FRAC(SEED_FRAC)) u_rom (
      .idx  ({~op[23], op[22 -: SEED_IDX]}),
      .seed (seed)
   );

   assign a_q    = op[23] ? {2'b01, op[22:0]} : {1'b1, op[22:0], 1'b0};
   assign y_seed = {1'b0, seed, {(FRAC_BITS - SEED_FRAC){1'b0}}};
   assign calc_en = fire && (cls == CL_NORMAL);

   rsqrt_newton #(.FRAC_BITS(FRAC_BITS), .STEPS(NR_STEPS)) u_nr (
      .clk    (clk),
      .rst_n  (rst_n),
      .chk_en (calc_en),
      .a_q    (a_q),
      .y_seed (y_seed),
      .y_out  (y_fin)
   );

   rsqrt_round_pack #(.FRAC_BITS(FRAC_BITS)) u_pack (
      .clk    (clk),
      .rst_n  (rst_n),
      .chk_en (calc_en),
      .y      (y_fin),
      .op_exp (op[30:23]),
      .res    (norm_res)
   );

   assign lane_on  = !in_mask_en || in_mask_bit;
   assign lane_val = !lane_on ? (in_zeroing ? 32'h0 : in_dst_lo)
                   : (cls == CL_NORMAL) ? norm_res : spec_res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_data    <= '0;
         out_invalid <= 1'b0;
         out_divzero <= 1'b0;
      end else if (fire) begin
         out_valid   <= 1'b1;
         out_data    <= {in_src1[VEC_W-1:LANE], lane_val};
         out_invalid <= lane_on && spec_inv;
         out_divzero <= lane_on && spec_dz;
      end else if (out_ready) begin
         out_valid   <= 1'b0;
      end
   end

   // R9
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                     && $stable(out_invalid) && $stable(out_divzero)))
      else $error("result changed while stalled");

   // R9
   one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid)
      else $error("accepted operation produced no result");

   // R8
   upper_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_data[VEC_W-1:LANE] == $past(in_src1[VEC_W-1:LANE])))
      else $error("upper lanes not copied");

   // R7
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_mask_en && !in_mask_bit) |=> (!out_invalid && !out_divzero))
      else $error("flag raised for masked-off lane");

   // R7
   zeroing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_mask_en && !in_mask_bit && in_zeroing)
         |=> (out_data[LANE-1:0] == 32'h0))
      else $error("zeroing mode left a non-zero lane");

   // R5
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_invalid && out_divzero))
      else $error("both flags raised");

endmodule

// File: tb/tb_rsqrt_unit.sv
`timescale 1ns/1ps
module tb_rsqrt_unit;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [127:0] in_src1 = '0;
   logic [127:0] in_src2 = '0;
   logic [31:0]  in_dst_lo = '0;
   logic         in_mask_en = 1'b0;
   logic         in_mask_bit = 1'b0;
   logic         in_zeroing = 1'b0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [127:0] out_data;
   logic         out_invalid;
   logic         out_divzero;

   int n_chk  = 0;
   int n_fail = 0;
   bit stall_mode = 1'b0;

   logic [127:0] q_data [$];
   logic         q_inv  [$];
   logic         q_dz   [$];
   bit           q_apx  [$];
   real          q_ref  [$];
   string        q_tag  [$];

   always #2 clk = ~clk;

   rsqrt_unit dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_src1(in_src1), .in_src2(in_src2), .in_dst_lo(in_dst_lo),
      .in_mask_en(in_mask_en), .in_mask_bit(in_mask_bit), .in_zeroing(in_zeroing),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_invalid(out_invalid), .out_divzero(out_divzero)
   );

   function automatic real f2r(logic [31:0] b);
      logic [63:0] d;
      if (b[30:23] == 8'h00) return 0.0;
      d = {b[31], 11'(int'(b[30:23]) - 127 + 1023), b[22:0], 29'd0};
      return $bitstoreal(d);
   endfunction

   task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // Driver: computes the expected item from the requirements, offers it, queues it on acceptance
   task automatic send(logic [31:0] op, logic [127:0] s1, logic [31:0] dlo,
                       bit men, bit mbit, bit zer, string tag);
      logic [31:0] lo;
      bit inv, dz, apx, acc;
      real rv;
      int e;
      lo = 32'h0; inv = 0; dz = 0; apx = 0; rv = 0.0;
      e = int'(op[30:23]);
      if (e == 255 && op[22:0] != 0) begin            // R3
         lo = op | 32'h0040_0000; inv = !op[22];
      end else if (e == 0) begin                      // R5
         lo = op[31] ? 32'hFF80_0000 : 32'h7F80_0000; dz = 1;
      end else if (e == 255 && !op[31]) begin         // R6
         lo = 32'h0;
      end else if (op[31]) begin                      // R4
         lo = 32'hFFC0_0000; inv = 1;
      end else if (op[22:0] == 0 && e[0]) begin       // R2
         lo = {1'b0, 8'(127 - (e - 127) / 2), 23'd0};
      end else begin                                  // R1
         apx = 1; rv = 1.0 / $sqrt(f2r(op));
      end
      if (men && !mbit) begin                         // R7
         lo = zer ? 32'h0 : dlo; inv = 0; dz = 0; apx = 0;
      end
      @(negedge clk);
      in_src1 = s1; in_src2 = {$urandom, $urandom, $urandom, op};
      in_dst_lo = dlo; in_mask_en = men; in_mask_bit = mbit; in_zeroing = zer;
      in_valid = 1'b1;
      forever begin
         #1.5;
         acc = in_ready;
         @(posedge clk);
         if (acc) break;
         @(negedge clk);
      end
      q_data.push_back({s1[127:32], lo}); q_inv.push_back(inv); q_dz.push_back(dz);
      q_apx.push_back(apx); q_ref.push_back(rv); q_tag.push_back(tag);
   endtask

   task automatic drain();
      @(negedge clk);
      in_valid = 1'b0;
      for (int i = 0; i < 200 && q_data.size() != 0; i++) @(negedge clk);
      check(q_data.size() == 0, "R9 drain", 128'(q_data.size()), 128'd0);
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   // Stall pattern on the output side
   always @(negedge clk) out_ready <= stall_mode ? (($urandom % 3) != 0) : 1'b1;

   // Monitor: compares each handed-over result with the scoreboard, and checks stall hold
   logic [127:0] held_data;
   logic         held_inv, held_dz;
   bit           held = 0;
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (held) begin
            // R9 result held while stalled
            check(out_valid && out_data == held_data && out_invalid == held_inv
                  && out_divzero == held_dz, "R9 hold", out_data, held_data);
         end
         held = 0;
         if (out_valid && !out_ready) begin
            held = 1; held_data = out_data; held_inv = out_invalid; held_dz = out_divzero;
         end
         if (out_valid && out_ready) begin
            if (q_data.size() == 0) begin
               check(0, "R9 unexpected result", out_data, 128'd0);
            end else begin
               logic [127:0] ed;
               bit apx, ok;
               real rv, gv, rel;
               string tg;
               ed = q_data.pop_front(); apx = q_apx.pop_front(); rv = q_ref.pop_front();
               tg = q_tag.pop_front();
               ok = (out_invalid == q_inv.pop_front()) && (out_divzero == q_dz.pop_front());
               if (apx) begin
                  gv = f2r(out_data[31:0]);
                  rel = (gv - rv) / rv;
                  if (rel < 0.0) rel = -rel;
                  ok = ok && (out_data[127:32] == ed[127:32]) && !out_data[31]
                       && (rel < 2.0 ** -23);
                  check(ok, tg, out_data, {ed[127:32], 32'(longint'(rv * 1.0e9))});
               end else begin
                  check(ok && out_data == ed, tg, out_data, ed);
               end
            end
         end
      end
   end

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_up();
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R10
      check(!out_valid && in_ready, "R10 reset state", {126'd0, out_valid, in_ready}, 128'd1);

      // Special operands
      send(32'h7FC1_2345, rnd128(), 0, 0, 0, 0, "R3 quiet NaN");
      send(32'h7F80_0001, rnd128(), 0, 0, 0, 0, "R3 signalling NaN");
      send(32'hFF81_2345, rnd128(), 0, 0, 0, 0, "R3 negative signalling NaN");
      send(32'hFFFF_FFFF, rnd128(), 0, 0, 0, 0, "R3 negative quiet NaN");
      send(32'hBF80_0000, rnd128(), 0, 0, 0, 0, "R4 minus one");
      send(32'hFF80_0000, rnd128(), 0, 0, 0, 0, "R4 minus infinity");
      send(32'h8080_0000, rnd128(), 0, 0, 0, 0, "R4 smallest negative normal");
      send(32'h0000_0000, rnd128(), 0, 0, 0, 0, "R5 plus zero");
      send(32'h8000_0000, rnd128(), 0, 0, 0, 0, "R5 minus zero");
      send(32'h0000_0001, rnd128(), 0, 0, 0, 0, "R5 positive denormal");
      send(32'h807F_FFFF, rnd128(), 0, 0, 0, 0, "R5 negative denormal");
      send(32'h7F80_0000, rnd128(), 0, 0, 0, 0, "R6 plus infinity");
      drain();

      // Exact even powers of two
      for (int n = -63; n <= 63; n += 3) begin
         send({1'b0, 8'(127 - 2 * n), 23'd0}, rnd128(), 0, 0, 0, 0, "R2 even power");
      end
      send(32'h3F80_0000, rnd128(), 0, 0, 0, 0, "R2 one");
      drain();

      // Random normals with back-to-back traffic and output stalls
      stall_mode = 1'b1;
      for (int i = 0; i < 400; i++) begin
         logic [7:0] ex;
         ex = 8'(1 + ($urandom % 254));
         send({1'b0, ex, 23'($urandom)}, rnd128(), $urandom, 0, 0, 0, "R1 random normal");
      end
      send(32'h7F7F_FFFF, rnd128(), 0, 0, 0, 0, "R1 largest normal");
      send(32'h0080_0000, rnd128(), 0, 0, 0, 0, "R1 smallest normal");
      send(32'h4000_0000, rnd128(), 0, 0, 0, 0, "R1 two");
      drain();

      // Masking modes over every operand class, R8 pass-through on each
      for (int i = 0; i < 120; i++) begin
         logic [31:0] op;
         case (i % 6)
            0: op = 32'h7F80_0001;
            1: op = 32'h8000_0000;
            2: op = 32'hC040_0000;
            3: op = {1'b0, 8'(1 + ($urandom % 254)), 23'($urandom)};
            4: op = 32'h7F80_0000;
            default: op = 32'h3E80_0000;
         endcase
         send(op, rnd128(), $urandom, 1'($urandom), 1'($urandom), 1'($urandom),
              "R7 R8 masking mix");
      end
      stall_mode = 1'b0;
      drain();

      repeat (4) @(negedge clk);
      finish_up();
   end

endmodule